// File: doc/BRIEF.md
# Register Index Cache with LRU Replacement

This block keeps a short, fully associative list of physical vector register indices that were written recently by arithmetic instructions on one SIMD lane group. No register data is stored. When an instruction executes, its destination indices enter a fixed-length delay line. Once they leave it, they are applied to the list, and the least-recently-used entry is replaced when the list is full.

A combinational probe port reports whether an index is present. The dependency check port takes up to three source operands and up to four destination operands, each with a scoreboard busy flag. It reports the operands ready unless a busy operand is missing from the list, so a cached register never causes a read-after-write or write-after-any stall. Two counters gather read and write hits. Each hit is weighted by the number of active lanes in the execution mask.

A capacity of zero removes the list completely. Any other capacity is expected to be even.

Top module: `regidx_cache`

## Requirements
- R1: After a synchronous reset, every lookup misses and both hit counters read zero.
- R2: With CAPACITY = 0 nothing is ever recorded: probe_hit stays 0, the hit counters stay 0, and chk_ready is 0 whenever any valid check operand is busy.
- R3: Destination indices are recorded only when exe_valid is high and none of exe_is_load, exe_is_atomic and exe_is_sync is set.
- R4: A recorded index becomes visible to lookups DELAY clock edges after the edge that samples exe_valid (default 2). Before that, a lookup of the same index returns the earlier state.
- R5: Recording an index already present makes it the most recent entry and evicts nothing. If it is already the most recent entry, the order does not change.
- R6: Recording an absent index adds it without eviction while fewer than CAPACITY entries are held. When the list is full, the least-recently-used entry is replaced.
- R7: Destination slots of one instruction are applied in ascending order within one cycle, slot 0 first (bit i of exe_dst_vld and byte lane i of exe_dst_idx form slot i). Slot 0 therefore ends up the oldest of the group.
- R8: chk_ready is 0 exactly when some valid source or destination check operand is busy and its index is not in the list.
- R9: On each edge where exe_valid is high, rd_hits grows by popcount(exe_mask) for every valid source index found in the list, and wr_hits grows by the same amount for every valid destination index found. Membership is judged on the state before that edge's update, and all instruction kinds are counted.
- R10: The list never holds the same index twice, and the recency ranks of the valid entries are all distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exe_valid | input | 1 | An instruction executes this cycle |
| exe_is_load | input | 1 | Executing instruction is a load |
| exe_is_atomic | input | 1 | Executing instruction is an atomic |
| exe_is_sync | input | 1 | Executing instruction is a memory synchronisation |
| exe_mask | input | LANES | Active lane mask |
| exe_src_vld | input | NSRC | Source operand valid flags |
| exe_src_idx | input | NSRC*IDX_W | Source register indices |
| exe_dst_vld | input | SLOTS | Destination slot valid flags |
| exe_dst_idx | input | SLOTS*IDX_W | Destination register indices |
| chk_src_vld | input | NSRC | Check: source operand valid |
| chk_src_idx | input | NSRC*IDX_W | Check: source indices |
| chk_src_busy | input | NSRC | Check: scoreboard busy per source |
| chk_dst_vld | input | SLOTS | Check: destination operand valid |
| chk_dst_idx | input | SLOTS*IDX_W | Check: destination indices |
| chk_dst_busy | input | SLOTS | Check: scoreboard busy per destination |
| chk_ready | output | 1 | Operands ready (no stall) |
| probe_idx | input | IDX_W | Lookup index |
| probe_hit | output | 1 | Lookup index is present |
| rd_hits | output | CNT_W | Lane-weighted source hit count |
| wr_hits | output | CNT_W | Lane-weighted destination hit count |

## Verification
On every cycle the assertions check that no index is held twice and that the recency ranks stay distinct. They also check that the list changes only when the delay line delivers a record, that the last slot of a delivered group is present afterwards, and that an operand set with no busy flag is always ready. They further check that the list is empty right after reset and that the counters never step back. The exact LRU victim order, the slot ordering within a group, the filtering of memory instructions, the DELAY visibility point and the lane-weighted counter sums depend on stimulus history. Only the bench's directed sequences show those.

// File: rtl/regidx_cache_pkg.sv
package regidx_cache_pkg;
  // Storage size used when the cache is disabled (arrays must not be empty)
  function automatic int eff_cap(input int cap);
    return (cap > 0) ? cap : 1;
  endfunction

  // Width of the per-entry recency rank
  function automatic int rank_w(input int cap);
    return (cap > 2) ? $clog2(cap) : 1;
  endfunction
endpackage

// File: rtl/regidx_delay.sv
module regidx_delay #(
  parameter int DELAY = 2,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  // The LRU state register supplies the final stage, so DELAY-1 stages live here
  generate
    if (DELAY <= 1) begin : g_pass
      assign dout = din;
    end else begin : g_pipe
      localparam int NST = DELAY - 1;
      logic [W-1:0] stg [NST];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < NST; k++) stg[k] <= '0;
        end else begin
          stg[0] <= din;
          for (int k = 1; k < NST; k++) stg[k] <= stg[k-1];
        end
      end
      assign dout = stg[NST-1];
    end
  endgenerate
endmodule

// File: rtl/regidx_match.sv
module regidx_match #(
  parameter int CAP_E = 4,
  parameter int IDX_W = 8
) (
  input  logic [CAP_E-1:0]       ent_vld,
  input  logic [CAP_E*IDX_W-1:0] ent_tag,
  input  logic [IDX_W-1:0]       idx,
  output logic                   hit
);
  always_comb begin
    hit = 1'b0;
    for (int j = 0; j < CAP_E; j++)
      if (ent_vld[j] && ent_tag[j*IDX_W +: IDX_W] == idx) hit = 1'b1;
  end
endmodule

// File: rtl/regidx_lru.sv
module regidx_lru
  import regidx_cache_pkg::*;
#(
  parameter int CAPACITY = 4,
  parameter int IDX_W    = 8,
  parameter int SLOTS    = 4,
  localparam int CAP_E   = eff_cap(CAPACITY),
  localparam int AGE_W   = rank_w(CAP_E)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [SLOTS-1:0]       ins_vld,
  input  logic [SLOTS*IDX_W-1:0] ins_idx,
  output logic [CAP_E-1:0]       ent_vld,
  output logic [CAP_E*IDX_W-1:0] ent_tag,
  output logic [CAP_E*AGE_W-1:0] ent_age
);
  logic [CAP_E-1:0] vld_q, vld_n;
  logic [IDX_W-1:0] tag_q [CAP_E];
  logic [IDX_W-1:0] tag_n [CAP_E];
  logic [AGE_W-1:0] age_q [CAP_E];
  logic [AGE_W-1:0] age_n [CAP_E];
  logic [IDX_W-1:0] cur;
  logic             hit, spare;
  int               pos;

  // Slots applied one after another; rank 0 is most recent
  always_comb begin
    vld_n = vld_q;
    tag_n = tag_q;
    age_n = age_q;
    cur   = '0;
    hit   = 1'b0;
    spare = 1'b0;
    pos   = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (ins_vld[s]) begin
        cur   = ins_idx[s*IDX_W +: IDX_W];
        hit   = 1'b0;
        spare = 1'b0;
        pos   = 0;
        for (int j = 0; j < CAP_E; j++)
          if (vld_n[j] && tag_n[j] == cur) begin
            hit = 1'b1;
            pos = j;
          end
        if (hit) begin
          for (int j = 0; j < CAP_E; j++)
            if (vld_n[j] && age_n[j] < age_n[pos]) age_n[j] = age_n[j] + AGE_W'(1);
          age_n[pos] = '0;
        end else begin
          for (int j = 0; j < CAP_E; j++)
            if (!vld_n[j] && !spare) begin
              spare = 1'b1;
              pos   = j;
            end
          if (!spare)
            for (int j = 0; j < CAP_E; j++)
              if (age_n[j] == AGE_W'(CAP_E - 1)) pos = j;
          for (int j = 0; j < CAP_E; j++)
            if (vld_n[j]) age_n[j] = age_n[j] + AGE_W'(1);
          vld_n[pos] = 1'b1;
          tag_n[pos] = cur;
          age_n[pos] = '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int j = 0; j < CAP_E; j++) begin
        tag_q[j] <= '0;
        age_q[j] <= '0;
      end
    end else begin
      vld_q <= vld_n;
      for (int j = 0; j < CAP_E; j++) begin
        tag_q[j] <= tag_n[j];
        age_q[j] <= age_n[j];
      end
    end
  end

  assign ent_vld = vld_q;
  generate
    for (genvar j = 0; j < CAP_E; j++) begin : g_flat
      assign ent_tag[j*IDX_W +: IDX_W] = tag_q[j];
      assign ent_age[j*AGE_W +: AGE_W] = age_q[j];
    end
  endgenerate
endmodule

// File: rtl/regidx_cache.sv
module regidx_cache
  import regidx_cache_pkg::*;
#(
  parameter int CAPACITY = 4,
  parameter int DELAY    = 2,
  parameter int IDX_W    = 8,
  parameter int SLOTS    = 4,
  parameter int NSRC     = 3,
  parameter int LANES    = 16,
  parameter int CNT_W    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   exe_valid,
  input  logic                   exe_is_load,
  input  logic                   exe_is_atomic,
  input  logic                   exe_is_sync,
  input  logic [LANES-1:0]       exe_mask,
  input  logic [NSRC-1:0]        exe_src_vld,
  input  logic [NSRC*IDX_W-1:0]  exe_src_idx,
  input  logic [SLOTS-1:0]       exe_dst_vld,
  input  logic [SLOTS*IDX_W-1:0] exe_dst_idx,
  input  logic [NSRC-1:0]        chk_src_vld,
  input  logic [NSRC*IDX_W-1:0]  chk_src_idx,
  input  logic [NSRC-1:0]        chk_src_busy,
  input  logic [SLOTS-1:0]       chk_dst_vld,
  input  logic [SLOTS*IDX_W-1:0] chk_dst_idx,
  input  logic [SLOTS-1:0]       chk_dst_busy,
  output logic                   chk_ready,
  input  logic [IDX_W-1:0]       probe_idx,
  output logic                   probe_hit,
  output logic [CNT_W-1:0]       rd_hits,
  output logic [CNT_W-1:0]       wr_hits
);
  localparam int CAP_E = eff_cap(CAPACITY);
  localparam int AGE_W = rank_w(CAP_E);
  localparam int PW    = SLOTS + SLOTS * IDX_W;
  localparam int Q_CS  = 1;
  localparam int Q_CD  = Q_CS + NSRC;
  localparam int Q_ES  = Q_CD + SLOTS;
  localparam int Q_ED  = Q_ES + NSRC;
  localparam int NQ    = Q_ED + SLOTS;

  logic [CAP_E-1:0]       ent_vld;
  logic [CAP_E*IDX_W-1:0] ent_tag;
  logic [CAP_E*AGE_W-1:0] ent_age;
  logic [SLOTS-1:0]       ins_vld_d;
  logic [SLOTS*IDX_W-1:0] ins_idx_d;
  logic [PW-1:0]          pipe_in, pipe_out;
  logic                   ins_en;

  // Memory-type instructions never record their destinations
  assign ins_en  = exe_valid & ~(exe_is_load | exe_is_atomic | exe_is_sync);
  assign pipe_in = {(ins_en ? exe_dst_vld : {SLOTS{1'b0}}), exe_dst_idx};

  regidx_delay #(.DELAY(DELAY), .W(PW)) u_delay (
    .clk(clk), .rst(rst), .din(pipe_in), .dout(pipe_out)
  );
  assign ins_vld_d = pipe_out[PW-1 -: SLOTS];
  assign ins_idx_d = pipe_out[SLOTS*IDX_W-1:0];

  generate
    if (CAPACITY == 0) begin : g_off
      assign ent_vld = '0;
      assign ent_tag = '0;
      assign ent_age = '0;
    end else begin : g_on
      regidx_lru #(.CAPACITY(CAPACITY), .IDX_W(IDX_W), .SLOTS(SLOTS)) u_lru (
        .clk(clk), .rst(rst), .ins_vld(ins_vld_d), .ins_idx(ins_idx_d),
        .ent_vld(ent_vld), .ent_tag(ent_tag), .ent_age(ent_age)
      );
    end
  endgenerate

  // Every lookup point gets its own parallel comparator set
  logic [IDX_W-1:0] qidx [NQ];
  logic [NQ-1:0]    qhit;

  always_comb begin
    qidx[0] = probe_idx;
    for (int i = 0; i < NSRC; i++) begin
      qidx[Q_CS+i] = chk_src_idx[i*IDX_W +: IDX_W];
      qidx[Q_ES+i] = exe_src_idx[i*IDX_W +: IDX_W];
    end
    for (int i = 0; i < SLOTS; i++) begin
      qidx[Q_CD+i] = chk_dst_idx[i*IDX_W +: IDX_W];
      qidx[Q_ED+i] = exe_dst_idx[i*IDX_W +: IDX_W];
    end
  end

  generate
    for (genvar q = 0; q < NQ; q++) begin : g_q
      regidx_match #(.CAP_E(CAP_E), .IDX_W(IDX_W)) u_m (
        .ent_vld(ent_vld), .ent_tag(ent_tag), .idx(qidx[q]), .hit(qhit[q])
      );
    end
  endgenerate

  assign probe_hit = qhit[0];

  always_comb begin
    chk_ready = 1'b1;
    for (int i = 0; i < NSRC; i++)
      if (chk_src_vld[i] && chk_src_busy[i] && !qhit[Q_CS+i]) chk_ready = 1'b0;
    for (int i = 0; i < SLOTS; i++)
      if (chk_dst_vld[i] && chk_dst_busy[i] && !qhit[Q_CD+i]) chk_ready = 1'b0;
  end

  int unsigned      n_rd, n_wr, lanes;
  logic [CNT_W-1:0] rd_inc, wr_inc;

  always_comb begin
    n_rd  = 0;
    n_wr  = 0;
    lanes = $countones(exe_mask);
    for (int i = 0; i < NSRC; i++)
      if (exe_src_vld[i] && qhit[Q_ES+i]) n_rd = n_rd + 1;
    for (int i = 0; i < SLOTS; i++)
      if (exe_dst_vld[i] && qhit[Q_ED+i]) n_wr = n_wr + 1;
    rd_inc = CNT_W'(n_rd * lanes);
    wr_inc = CNT_W'(n_wr * lanes);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hits <= '0;
      wr_hits <= '0;
    end else if (exe_valid) begin
      rd_hits <= rd_hits + rd_inc;
      wr_hits <= wr_hits + wr_inc;
    end
  end
endmodule

// File: rtl/regidx_cache_chk.sv
module regidx_cache_chk #(
  parameter int CAPACITY = 4,
  parameter int CAP_E    = 4,
  parameter int AGE_W    = 2,
  parameter int IDX_W    = 8,
  parameter int SLOTS    = 4,
  parameter int NSRC     = 3,
  parameter int CNT_W    = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic [CAP_E-1:0]       ent_vld,
  input logic [CAP_E*IDX_W-1:0] ent_tag,
  input logic [CAP_E*AGE_W-1:0] ent_age,
  input logic [SLOTS-1:0]       ins_vld_d,
  input logic [SLOTS*IDX_W-1:0] ins_idx_d,
  input logic [NSRC-1:0]        chk_src_vld,
  input logic [NSRC-1:0]        chk_src_busy,
  input logic [SLOTS-1:0]       chk_dst_vld,
  input logic [SLOTS-1:0]       chk_dst_busy,
  input logic                   chk_ready,
  input logic [CNT_W-1:0]       rd_hits,
  input logic [CNT_W-1:0]       wr_hits
);
  function automatic logic holds(input logic [CAP_E-1:0] v,
                                 input logic [CAP_E*IDX_W-1:0] t,
                                 input logic [IDX_W-1:0] x);
    logic r;
    r = 1'b0;
    for (int j = 0; j < CAP_E; j++)
      if (v[j] && t[j*IDX_W +: IDX_W] == x) r = 1'b1;
    return r;
  endfunction

  logic busy_any;
  assign busy_any = (|(chk_src_vld & chk_src_busy)) | (|(chk_dst_vld & chk_dst_busy));

  generate
    for (genvar i = 0; i < CAP_E; i++) begin : g_i
      for (genvar j = i + 1; j < CAP_E; j++) begin : g_j
        AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (rst)
          !(ent_vld[i] && ent_vld[j] &&
            ent_tag[i*IDX_W +: IDX_W] == ent_tag[j*IDX_W +: IDX_W])); // R10
        AST_RANK_UNIQUE: assert property (@(posedge clk) disable iff (rst)
          !(ent_vld[i] && ent_vld[j] &&
            ent_age[i*AGE_W +: AGE_W] == ent_age[j*AGE_W +: AGE_W])); // R10
      end
    end
    if (CAPACITY > 0) begin : g_fill
      AST_LAST_SLOT_PRESENT: assert property (@(posedge clk) disable iff (rst)
        ins_vld_d[SLOTS-1] |=> holds(ent_vld, ent_tag,
          $past(ins_idx_d[(SLOTS-1)*IDX_W +: IDX_W]))); // R7
    end else begin : g_zero
      AST_DISABLED_STALLS: assert property (@(posedge clk) disable iff (rst)
        busy_any |-> !chk_ready); // R2
    end
  endgenerate

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ent_vld == '0 && rd_hits == '0 && wr_hits == '0)); // R1
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (ins_vld_d == '0) |=> ($stable(ent_vld) && $stable(ent_tag))); // R4
  AST_READY_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    !busy_any |-> chk_ready); // R8
  AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    (rd_hits >= $past(rd_hits)) && (wr_hits >= $past(wr_hits))); // R9
endmodule

bind regidx_cache regidx_cache_chk #(
  .CAPACITY(CAPACITY), .CAP_E(CAP_E), .AGE_W(AGE_W), .IDX_W(IDX_W),
  .SLOTS(SLOTS), .NSRC(NSRC), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .ent_vld(ent_vld), .ent_tag(ent_tag), .ent_age(ent_age),
  .ins_vld_d(ins_vld_d), .ins_idx_d(ins_idx_d),
  .chk_src_vld(chk_src_vld), .chk_src_busy(chk_src_busy),
  .chk_dst_vld(chk_dst_vld), .chk_dst_busy(chk_dst_busy),
  .chk_ready(chk_ready), .rd_hits(rd_hits), .wr_hits(wr_hits)
);

// File: tb/regidx_cache_bench.sv
module regidx_cache_bench;
  localparam int DELAY = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        exe_valid, exe_is_load, exe_is_atomic, exe_is_sync;
  logic [15:0] exe_mask;
  logic [2:0]  exe_src_vld;
  logic [23:0] exe_src_idx;
  logic [3:0]  exe_dst_vld;
  logic [31:0] exe_dst_idx;
  logic [2:0]  chk_src_vld, chk_src_busy;
  logic [23:0] chk_src_idx;
  logic [3:0]  chk_dst_vld, chk_dst_busy;
  logic [31:0] chk_dst_idx;
  logic [7:0]  probe_idx;
  logic        chk_ready, probe_hit, chk_ready_z, probe_hit_z;
  logic [31:0] rd_hits, wr_hits, rd_hits_z, wr_hits_z;

  int  checks = 0;
  int  errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  regidx_cache #(.DELAY(DELAY)) u_regidx_cache (
    .clk(clk), .rst(rst), .exe_valid(exe_valid), .exe_is_load(exe_is_load),
    .exe_is_atomic(exe_is_atomic), .exe_is_sync(exe_is_sync), .exe_mask(exe_mask),
    .exe_src_vld(exe_src_vld), .exe_src_idx(exe_src_idx),
    .exe_dst_vld(exe_dst_vld), .exe_dst_idx(exe_dst_idx),
    .chk_src_vld(chk_src_vld), .chk_src_idx(chk_src_idx), .chk_src_busy(chk_src_busy),
    .chk_dst_vld(chk_dst_vld), .chk_dst_idx(chk_dst_idx), .chk_dst_busy(chk_dst_busy),
    .chk_ready(chk_ready), .probe_idx(probe_idx), .probe_hit(probe_hit),
    .rd_hits(rd_hits), .wr_hits(wr_hits)
  );

  regidx_cache #(.CAPACITY(0), .DELAY(DELAY)) u_regidx_cache_z (
    .clk(clk), .rst(rst), .exe_valid(exe_valid), .exe_is_load(exe_is_load),
    .exe_is_atomic(exe_is_atomic), .exe_is_sync(exe_is_sync), .exe_mask(exe_mask),
    .exe_src_vld(exe_src_vld), .exe_src_idx(exe_src_idx),
    .exe_dst_vld(exe_dst_vld), .exe_dst_idx(exe_dst_idx),
    .chk_src_vld(chk_src_vld), .chk_src_idx(chk_src_idx), .chk_src_busy(chk_src_busy),
    .chk_dst_vld(chk_dst_vld), .chk_dst_idx(chk_dst_idx), .chk_dst_busy(chk_dst_busy),
    .chk_ready(chk_ready_z), .probe_idx(probe_idx), .probe_hit(probe_hit_z),
    .rd_hits(rd_hits_z), .wr_hits(wr_hits_z)
  );

  // {record, recorded index, probed index, expected hit}; capacity 4
  localparam logic [17:0] TBL [14] = '{
    {1'b1, 8'd10, 8'd10, 1'b1},
    {1'b1, 8'd11, 8'd10, 1'b1},
    {1'b1, 8'd12, 8'd11, 1'b1},
    {1'b1, 8'd13, 8'd12, 1'b1},
    {1'b1, 8'd10, 8'd10, 1'b1},
    {1'b1, 8'd14, 8'd11, 1'b0},
    {1'b1, 8'd15, 8'd12, 1'b0},
    {1'b1, 8'd13, 8'd14, 1'b1},
    {1'b1, 8'd16, 8'd10, 1'b0},
    {1'b1, 8'd16, 8'd13, 1'b1},
    {1'b1, 8'd17, 8'd14, 1'b0},
    {1'b0, 8'd0,  8'd15, 1'b1},
    {1'b1, 8'd18, 8'd15, 1'b0},
    {1'b0, 8'd0,  8'd13, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    exe_valid = 0; exe_is_load = 0; exe_is_atomic = 0; exe_is_sync = 0;
    exe_mask = '0; exe_src_vld = '0; exe_src_idx = '0;
    exe_dst_vld = '0; exe_dst_idx = '0;
    chk_src_vld = '0; chk_src_idx = '0; chk_src_busy = '0;
    chk_dst_vld = '0; chk_dst_idx = '0; chk_dst_busy = '0;
    probe_idx = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    idle();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Returns at the falling edge after the sampling edge
  task automatic exe(input logic [2:0] kind, input logic [15:0] mask,
                     input logic [2:0] sv, input logic [23:0] si,
                     input logic [3:0] dv, input logic [31:0] di);
    @(negedge clk);
    exe_valid = 1'b1;
    {exe_is_load, exe_is_atomic, exe_is_sync} = kind;
    exe_mask = mask; exe_src_vld = sv; exe_src_idx = si;
    exe_dst_vld = dv; exe_dst_idx = di;
    @(negedge clk);
    idle();
  endtask

  task automatic settle();
    repeat (DELAY - 1) @(negedge clk);
  endtask

  task automatic probe(input logic [7:0] idx, input logic exp, input string req);
    probe_idx = idx;
    #1;
    check(req, probe_hit, exp);
  endtask

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    probe(8'd10, 1'b0, "R1 lookup after reset");
    check("R1 rd_hits after reset", rd_hits, 0);
    check("R1 wr_hits after reset", wr_hits, 0);

    exe(3'b000, 16'hFFFF, 3'b000, 24'd0, 4'b0001, {24'd0, 8'd10});
    probe(8'd10, 1'b0, "R4 old state one edge after execute");
    settle();
    probe(8'd10, 1'b1, "R4 visible after DELAY edges");

    do_reset();
    for (int r = 0; r < 14; r++) begin
      if (TBL[r][17]) begin
        exe(3'b000, 16'hFFFF, 3'b000, 24'd0, 4'b0001, {24'd0, TBL[r][16:9]});
        settle();
      end
      probe(TBL[r][8:1], TBL[r][0], "R5 R6 LRU table");
    end

    // Contents now 18,17,16,13 (most recent first)
    chk_src_vld = 3'b001; chk_src_idx = {16'd0, 8'd13}; chk_src_busy = 3'b001;
    #1;
    check("R8 busy cached source waived", chk_ready, 1);
    check("R2 disabled cache stalls busy source", chk_ready_z, 0);
    chk_src_idx = {16'd0, 8'd99};
    #1;
    check("R8 busy uncached source stalls", chk_ready, 0);
    idle();
    chk_dst_vld = 4'b0001; chk_dst_idx = {24'd0, 8'd16}; chk_dst_busy = 4'b0001;
    #1;
    check("R8 busy cached destination waived", chk_ready, 1);
    chk_dst_idx = {24'd0, 8'd98};
    #1;
    check("R8 busy uncached destination stalls", chk_ready, 0);
    chk_dst_busy = 4'b0000;
    #1;
    check("R8 idle uncached destination ready", chk_ready, 1);
    idle();
    probe_idx = 8'd13;
    #1;
    check("R2 disabled cache lookup", probe_hit_z, 0);

    do_reset();
    exe(3'b100, 16'hFFFF, 3'b000, 24'd0, 4'b0001, {24'd0, 8'd40});
    exe(3'b010, 16'hFFFF, 3'b000, 24'd0, 4'b0001, {24'd0, 8'd41});
    exe(3'b001, 16'hFFFF, 3'b000, 24'd0, 4'b0001, {24'd0, 8'd42});
    exe(3'b000, 16'hFFFF, 3'b000, 24'd0, 4'b0001, {24'd0, 8'd43});
    settle();
    probe(8'd40, 1'b0, "R3 load not recorded");
    probe(8'd41, 1'b0, "R3 atomic not recorded");
    probe(8'd42, 1'b0, "R3 sync not recorded");
    probe(8'd43, 1'b1, "R3 arithmetic recorded");

    do_reset();
    exe(3'b000, 16'hFFFF, 3'b000, 24'd0, 4'b1111, {8'd23, 8'd22, 8'd21, 8'd20});
    exe(3'b000, 16'hFFFF, 3'b000, 24'd0, 4'b0001, {24'd0, 8'd24});
    settle();
    probe(8'd20, 1'b0, "R7 slot 0 oldest evicted");
    probe(8'd21, 1'b1, "R7 slot 1 kept");
    probe(8'd24, 1'b1, "R7 new entry present");

    do_reset();
    exe(3'b000, 16'hFFFF, 3'b000, 24'd0, 4'b0011, {16'd0, 8'd51, 8'd50});
    check("R9 no write hit on absent destinations", wr_hits, 0);
    settle();
    exe(3'b100, 16'h00FF, 3'b111, {8'd51, 8'd52, 8'd50}, 4'b0001, {24'd0, 8'd50});
    check("R9 read hits lane weighted", rd_hits, 16);
    check("R9 write hits lane weighted", wr_hits, 8);
    check("R2 disabled cache read hits", rd_hits_z, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule